// File: doc/BRIEF.md
# Vector Integer Reduction Sequencer

This block folds the active elements of a vector register group into a single scalar result. A command gives the operation, the element width, the number of elements, the source and destination register numbers and the masking controls. The engine reads a starting value from element 0 of one source register. It then walks the elements of a second source group one per cycle and combines each active element into a running accumulator. At the end it writes the accumulator into element 0 of the destination register through a byte-enabled write port.

A widening mode sums elements of one width into an accumulator of twice that width. Each source element is sign-extended or zero-extended first, depending on a control input. An empty reduction (zero length) completes without touching the destination. A widening request at the 64-bit source width is refused with an illegal-operation flag.

The register file sits outside the block. Its read port is combinational: the data for the address the block drives is expected back in the same cycle. Decode and legality screening of the wider command stream are also done elsewhere.

Top module: `vec_reduce_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `illegal`, `dirty_set`, `vstart_clr` and `rf_wr_en` are low.
- R2: A `start` sampled while idle is accepted. `busy` is high from the next cycle through the cycle where `done` is high, and `done` lasts exactly one cycle. A `start` sampled while busy is ignored: it produces no extra completion and no write.
- R3: The accumulator starts from element 0 of register `vs1`, read at the result width.
- R4: Element widths are coded in `sew` as 0, 1, 2, 3 for 8, 16, 32, 64 bits. Element i of the group lives in register `vs2 + (i*W)/VLEN` at bit offset `(i*W) mod VLEN`. Elements 0 to `vl-1` are visited in increasing order, one per cycle. For a legal non-empty command, `done` rises `vl+2` clock edges after the edge that samples `start`.
- R5: The `op` codes are 0 sum, 1 unsigned min, 2 signed min, 3 unsigned max, 4 signed max, 5 and, 6 or, 7 xor. The sum wraps modulo the result width, and signed compares use the element's top bit as its sign.
- R6: With `mask_en` high, element i contributes only when bit i of `mask_bits` is 1 and is otherwise skipped with the accumulator unchanged. With `mask_en` low, every element contributes. `mask_bits` is sampled only in the `start` cycle, so later changes have no effect.
- R7: The result is written only to element 0 of register `vd`. `rf_wr_be` has a 1 for bytes 0 to (result width / 8) - 1 and a 0 for every other byte, so the rest of `vd` keeps its contents.
- R8: On completion of a legal non-empty command, `rf_wr_en`, `dirty_set` and `vstart_clr` pulse in the `done` cycle.
- R9: When `vl` is 0, `done` rises one edge after `start` is sampled. There is no write and no `dirty_set`, but `vstart_clr` pulses.
- R10: With `widen` high, the result width is twice the source width (8 to 16, 16 to 32, 32 to 64). The seed is read at the wide width, and `op` is ignored: the operation is always a sum.
- R11: In widening mode, each source element is sign-extended to the wide width when `sext` is 1 and zero-extended when it is 0.
- R12: `widen` high with `sew` = 3 gives an `illegal` pulse with `done`, one edge after `start`. There is no write, no `dirty_set` and no `vstart_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled while idle |
| op | input | 3 | Operation code |
| sew | input | 2 | Source element width code |
| widen | input | 1 | Widening-sum mode |
| sext | input | 1 | Sign-extend sources in widening mode |
| mask_en | input | 1 | Apply mask bits |
| mask_bits | input | VLEN | Per-element mask, sampled with start |
| vl | input | $clog2(VLEN+1) | Number of elements |
| vs1 | input | $clog2(NREG) | Seed register number |
| vs2 | input | $clog2(NREG) | First register of the source group |
| vd | input | $clog2(NREG) | Destination register number |
| rf_rd_addr | output | $clog2(NREG) | Register file read address |
| rf_rd_data | input | VLEN | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | $clog2(NREG) | Register file write address |
| rf_wr_data | output | VLEN | Write data, result in the low bits |
| rf_wr_be | output | VLEN/8 | Byte enables for the write |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Refused-command pulse |
| dirty_set | output | 1 | Vector state modified pulse |
| vstart_clr | output | 1 | Clear-start-index pulse |

## Verification
The bench targets the points where a reduction quietly gives a plausible but wrong scalar.

- Group crossings at every width, up to the full 128-element group at 8 bits. An engine that computes the register step or bit offset wrongly would fold in the wrong elements.
- Signed against unsigned min and max on data with the top bit set. Swapped compares give the opposite extreme.
- Masks that change after `start`, and a mask with every bit clear. If the mask is not captured at `start`, or if skipped elements are zeroed instead of passed over, the result moves.
- Partial-byte writes into a pre-filled destination. An engine that writes the whole register or the wrong byte span destroys neighbouring data.
- Zero length, the refused 64-bit widening, and a second `start` while busy. Each of these must leave the destination, the dirty pulse and the completion count exactly as the requirements state.

// File: rtl/vred_pkg.sv
package vred_pkg;

  typedef enum logic [2:0] {
    RED_SUM  = 3'd0,
    RED_MINU = 3'd1,
    RED_MIN  = 3'd2,
    RED_MAXU = 3'd3,
    RED_MAX  = 3'd4,
    RED_AND  = 3'd5,
    RED_OR   = 3'd6,
    RED_XOR  = 3'd7
  } red_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_STEP,
    ST_WRITE,
    ST_FINISH
  } red_state_e;

  // keep only the low 8 << code bits
  function automatic logic [63:0] fit_width(input logic [63:0] v, input logic [1:0] code);
    case (code)
      2'd0:    return {56'd0, v[7:0]};
      2'd1:    return {48'd0, v[15:0]};
      2'd2:    return {32'd0, v[31:0]};
      default: return v;
    endcase
  endfunction

  // replicate the top bit of an 8 << code wide value
  function automatic logic [63:0] sext_from(input logic [63:0] v, input logic [1:0] code);
    case (code)
      2'd0:    return {{56{v[7]}}, v[7:0]};
      2'd1:    return {{48{v[15]}}, v[15:0]};
      2'd2:    return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  // one reduction step at result width code
  function automatic logic [63:0] combine(input logic [63:0] a, input logic [63:0] b,
                                          input red_op_e op, input logic [1:0] code);
    logic [63:0] a_f, b_f, a_s, b_s, r;
    logic        lt_u, lt_s;
    a_f  = fit_width(a, code);
    b_f  = fit_width(b, code);
    a_s  = sext_from(a, code);
    b_s  = sext_from(b, code);
    lt_u = a_f < b_f;
    lt_s = $signed(a_s) < $signed(b_s);
    case (op)
      RED_SUM:  r = a + b;
      RED_MINU: r = lt_u ? a_f : b_f;
      RED_MIN:  r = lt_s ? a_f : b_f;
      RED_MAXU: r = lt_u ? b_f : a_f;
      RED_MAX:  r = lt_s ? b_f : a_f;
      RED_AND:  r = a & b;
      RED_OR:   r = a | b;
      default:  r = a ^ b;
    endcase
    return fit_width(r, code);
  endfunction

endpackage

// File: rtl/vred_elem_sel.sv
module vred_elem_sel
  import vred_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0]         reg_data,
  input  logic [$clog2(VLEN)-1:0] bit_off,
  input  logic [1:0]              code,
  output logic [63:0]             elem
);
  localparam int PADW = VLEN + 64;

  logic [PADW-1:0] padded;
  logic [63:0]     window;

  always_comb begin
    padded = {64'd0, reg_data};
    window = padded[bit_off +: 64];
    elem   = fit_width(window, code);
  end
endmodule

// File: rtl/vred_alu.sv
module vred_alu
  import vred_pkg::*;
(
  input  logic [63:0] acc,
  input  logic [63:0] raw,
  input  logic [2:0]  op,
  input  logic [1:0]  src_code,
  input  logic        widen,
  input  logic        sext,
  input  logic        active,
  output logic [63:0] acc_nxt,
  output logic [1:0]  res_code
);
  logic [63:0] src;
  red_op_e     eff_op;

  always_comb begin
    res_code = widen ? src_code + 2'd1 : src_code;
    src      = (widen && sext) ? sext_from(raw, src_code) : raw;
    eff_op   = widen ? RED_SUM : red_op_e'(op);
    acc_nxt  = active ? combine(acc, src, eff_op, res_code) : acc;
  end
endmodule

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int NREG = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                op_in,
  input  logic [1:0]                sew_in,
  input  logic                      widen_in,
  input  logic                      sext_in,
  input  logic                      mask_en_in,
  input  logic [VLEN-1:0]           mask_in,
  input  logic [$clog2(VLEN+1)-1:0] vl_in,
  input  logic [$clog2(NREG)-1:0]   vs1_in,
  input  logic [$clog2(NREG)-1:0]   vs2_in,
  input  logic [$clog2(NREG)-1:0]   vd_in,
  output logic                      busy,
  output logic                      done,
  output logic                      illegal,
  output logic                      dirty_set,
  output logic                      vstart_clr,
  output logic                      ph_seed,
  output logic                      ph_step,
  output logic                      ph_write,
  output logic [$clog2(VLEN)-1:0]   idx,
  output logic                      active,
  output logic [2:0]                op_q,
  output logic [1:0]                sew_q,
  output logic                      widen_q,
  output logic                      sext_q,
  output logic [$clog2(NREG)-1:0]   vs1_q,
  output logic [$clog2(NREG)-1:0]   vs2_q,
  output logic [$clog2(NREG)-1:0]   vd_q
);
  localparam int VLW = $clog2(VLEN + 1);
  localparam int IW  = $clog2(VLEN);

  red_state_e      state;
  logic [VLEN-1:0] mask_q;
  logic [VLW-1:0]  vl_q;
  logic            bad_q;
  logic            last;
  logic            accept;
  logic            bad_cmd;

  assign accept  = (state == ST_IDLE) && start;
  assign bad_cmd = widen_in && (sew_in == 2'd3);
  assign last    = (VLW'(idx) + VLW'(1)) == vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mask_q  <= '0;
      vl_q    <= '0;
      bad_q   <= 1'b0;
      idx     <= '0;
      op_q    <= '0;
      sew_q   <= '0;
      widen_q <= 1'b0;
      sext_q  <= 1'b0;
      vs1_q   <= '0;
      vs2_q   <= '0;
      vd_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mask_q  <= mask_en_in ? mask_in : '1;
            vl_q    <= vl_in;
            bad_q   <= bad_cmd;
            idx     <= '0;
            op_q    <= op_in;
            sew_q   <= sew_in;
            widen_q <= widen_in;
            sext_q  <= sext_in;
            vs1_q   <= vs1_in;
            vs2_q   <= vs2_in;
            vd_q    <= vd_in;
            if (bad_cmd || vl_in == '0) state <= ST_FINISH;
            else                        state <= ST_SEED;
          end
        end
        ST_SEED: state <= ST_STEP;
        ST_STEP: begin
          if (last) state <= ST_WRITE;
          else      idx   <= idx + IW'(1);
        end
        ST_WRITE:  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = state != ST_IDLE;
    ph_seed    = state == ST_SEED;
    ph_step    = state == ST_STEP;
    ph_write   = state == ST_WRITE;
    done       = ph_write || (state == ST_FINISH);
    illegal    = (state == ST_FINISH) && bad_q;
    dirty_set  = ph_write;
    vstart_clr = ph_write || ((state == ST_FINISH) && !bad_q);
    active     = mask_q[idx];
  end

  assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ignore_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> $stable(vd_q) && $stable(vl_q));
  assert_index_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_step && !last |=> ph_step && idx == $past(idx) + IW'(1));
  assert_mask_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask_q));
  assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && vl_in == '0 && !bad_cmd |=> done && vstart_clr && !dirty_set);
  assert_refuse_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !dirty_set && !vstart_clr);
  assert_refuse_fast_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bad_cmd |=> illegal);
endmodule

// File: rtl/vec_reduce_engine.sv
module vec_reduce_engine
  import vred_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int NREG = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                op,
  input  logic [1:0]                sew,
  input  logic                      widen,
  input  logic                      sext,
  input  logic                      mask_en,
  input  logic [VLEN-1:0]           mask_bits,
  input  logic [$clog2(VLEN+1)-1:0] vl,
  input  logic [$clog2(NREG)-1:0]   vs1,
  input  logic [$clog2(NREG)-1:0]   vs2,
  input  logic [$clog2(NREG)-1:0]   vd,
  output logic [$clog2(NREG)-1:0]   rf_rd_addr,
  input  logic [VLEN-1:0]           rf_rd_data,
  output logic                      rf_wr_en,
  output logic [$clog2(NREG)-1:0]   rf_wr_addr,
  output logic [VLEN-1:0]           rf_wr_data,
  output logic [VLEN/8-1:0]         rf_wr_be,
  output logic                      busy,
  output logic                      done,
  output logic                      illegal,
  output logic                      dirty_set,
  output logic                      vstart_clr
);
  localparam int IW    = $clog2(VLEN);
  localparam int RW    = $clog2(NREG);
  localparam int NBYTE = VLEN / 8;
  localparam int BPW   = IW + 6;

  logic          ph_seed, ph_step, ph_write, active;
  logic [IW-1:0] idx;
  logic [2:0]    op_q;
  logic [1:0]    sew_q, res_code, sel_code;
  logic          widen_q, sext_q;
  logic [RW-1:0] vs1_q, vs2_q, vd_q;
  logic [63:0]   acc, acc_nxt, elem;
  logic [BPW-1:0] bitpos;
  logic [IW-1:0] bit_off;

  vred_ctrl #(.VLEN(VLEN), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_in(op), .sew_in(sew), .widen_in(widen), .sext_in(sext),
    .mask_en_in(mask_en), .mask_in(mask_bits), .vl_in(vl),
    .vs1_in(vs1), .vs2_in(vs2), .vd_in(vd),
    .busy(busy), .done(done), .illegal(illegal), .dirty_set(dirty_set),
    .vstart_clr(vstart_clr), .ph_seed(ph_seed), .ph_step(ph_step),
    .ph_write(ph_write), .idx(idx), .active(active),
    .op_q(op_q), .sew_q(sew_q), .widen_q(widen_q), .sext_q(sext_q),
    .vs1_q(vs1_q), .vs2_q(vs2_q), .vd_q(vd_q)
  );

  // element i starts at bit i*W of the group
  always_comb begin
    bitpos     = BPW'(idx) << (3'd3 + {1'b0, sew_q});
    bit_off    = ph_seed ? '0 : bitpos[IW-1:0];
    sel_code   = ph_seed ? res_code : sew_q;
    rf_rd_addr = ph_seed ? vs1_q : vs2_q + RW'(bitpos[BPW-1:IW]);
  end

  vred_elem_sel #(.VLEN(VLEN)) u_sel (
    .reg_data(rf_rd_data), .bit_off(bit_off), .code(sel_code), .elem(elem)
  );

  vred_alu u_alu (
    .acc(acc), .raw(elem), .op(op_q), .src_code(sew_q), .widen(widen_q),
    .sext(sext_q), .active(active), .acc_nxt(acc_nxt), .res_code(res_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (ph_seed) acc <= elem;
    else if (ph_step) acc <= acc_nxt;
  end

  assign rf_wr_en   = ph_write;
  assign rf_wr_addr = vd_q;
  assign rf_wr_data = VLEN'(acc);

  for (genvar b = 0; b < NBYTE; b++) begin : g_be
    assign rf_wr_be[b] = ph_write && (b < (1 << res_code));
  end

  assert_skip_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_step && !active |=> acc == $past(acc));
  assert_write_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> done && rf_wr_be[0] && rf_wr_addr == vd_q);
  assert_write_marks_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> dirty_set && vstart_clr && !illegal);
  assert_seed_then_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_seed |=> ph_step && acc == $past(elem));
endmodule

// File: tb/vec_reduce_engine_bench.sv
module vec_reduce_engine_bench;
  localparam int VLEN = 128;
  localparam int NREG = 32;
  localparam int VLW  = $clog2(VLEN + 1);
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] sew = '0;
  logic widen = 1'b0, sext = 1'b0, mask_en = 1'b0;
  logic [VLEN-1:0] mask_bits = '0;
  logic [VLW-1:0] vl = '0;
  logic [RW-1:0] vs1 = '0, vs2 = '0, vd = '0;
  logic [RW-1:0] rf_rd_addr, rf_wr_addr;
  logic [VLEN-1:0] rf_rd_data, rf_wr_data;
  logic rf_wr_en, busy, done, illegal, dirty_set, vstart_clr;
  logic [VLEN/8-1:0] rf_wr_be;

  logic [VLEN-1:0] rf [NREG];
  logic tb_ld = 1'b0;
  logic [RW-1:0] tb_addr = '0;
  logic [VLEN-1:0] tb_data = '0;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign rf_rd_data = rf[rf_rd_addr];

  always @(posedge clk) begin
    if (tb_ld) rf[tb_addr] <= tb_data;
    else if (rf_wr_en)
      for (int b = 0; b < VLEN/8; b++)
        if (rf_wr_be[b]) rf[rf_wr_addr][8*b +: 8] <= rf_wr_data[8*b +: 8];
  end

  vec_reduce_engine #(.VLEN(VLEN), .NREG(NREG)) u_vec_reduce_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sew(sew), .widen(widen),
    .sext(sext), .mask_en(mask_en), .mask_bits(mask_bits), .vl(vl),
    .vs1(vs1), .vs2(vs2), .vd(vd), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .rf_wr_be(rf_wr_be), .busy(busy), .done(done), .illegal(illegal),
    .dirty_set(dirty_set), .vstart_clr(vstart_clr)
  );

  task automatic check(input string tag, input string what, input logic [VLEN-1:0] got,
                       input logic [VLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] tb_trunc(input logic [63:0] v, input int w);
    return (w >= 64) ? v : (v & ((64'd1 << w) - 64'd1));
  endfunction

  function automatic logic [63:0] tb_el(input int r, input int i, input int w);
    int bp = i * w;
    logic [VLEN-1:0] word = rf[r + bp / VLEN] >> (bp % VLEN);
    return tb_trunc(word[63:0], w);
  endfunction

  function automatic bit tb_slt(input logic [63:0] a, input logic [63:0] b, input int w);
    logic signed [63:0] x = a << (64 - w);
    logic signed [63:0] y = b << (64 - w);
    return x < y;
  endfunction

  function automatic logic [63:0] tb_model(input int o, input int w, input bit wd, input bit sx,
      input bit men, input logic [VLEN-1:0] m, input int n, input int s1, input int s2);
    int rw = wd ? 2 * w : w;
    logic [63:0] a = tb_el(s1, 0, rw);
    for (int i = 0; i < n; i++) begin
      logic [63:0] e;
      if (men && !m[i]) continue;
      e = tb_el(s2, i, w);
      if (wd) begin
        if (sx && e[w-1]) e = e | ~tb_trunc(64'hFFFF_FFFF_FFFF_FFFF, w);
        a = tb_trunc(a + e, rw);
      end else begin
        case (o)
          0: a = tb_trunc(a + e, w);
          1: a = (e < a) ? e : a;
          2: a = tb_slt(e, a, w) ? e : a;
          3: a = (a < e) ? e : a;
          4: a = tb_slt(a, e, w) ? e : a;
          5: a = a & e;
          6: a = a | e;
          default: a = a ^ e;
        endcase
      end
    end
    return a;
  endfunction

  task automatic load_reg(input int r, input logic [VLEN-1:0] d);
    @(negedge clk);
    tb_ld = 1'b1; tb_addr = RW'(r); tb_data = d;
    @(negedge clk);
    tb_ld = 1'b0;
  endtask

  task automatic fill_regs(input int seed);
    for (int r = 0; r < NREG; r++) begin
      logic [VLEN-1:0] d;
      for (int k = 0; k < VLEN/8; k++)
        d[8*k +: 8] = 8'((r * 53 + k * 29 + seed) ^ (k << 4) ^ (r << 3));
      load_reg(r, d);
    end
  endtask

  // issue one command, wait for done, check timing, flags and destination
  task automatic run_case(input string tag, input int o, input int sw, input bit wd,
      input bit sx, input bit men, input logic [VLEN-1:0] m, input int n,
      input int s1, input int s2, input int dst);
    int w = 8 << sw;
    int rw = wd ? 2 * w : w;
    bit bad = wd && (sw == 3);
    logic [63:0] res;
    logic [VLEN-1:0] exp_vd = rf[dst];
    int exp_lat = (bad || n == 0) ? 1 : n + 2;
    int lat = 0;
    if (!bad) begin
      res = tb_model(o, w, wd, sx, men, m, n, s1, s2);
      if (n != 0)
        for (int b = 0; b < rw / 8; b++) exp_vd[8*b +: 8] = res[8*b +: 8];
    end
    @(negedge clk);
    start = 1'b1; op = 3'(o); sew = 2'(sw); widen = wd; sext = sx; mask_en = men;
    mask_bits = m; vl = VLW'(n); vs1 = RW'(s1); vs2 = RW'(s2); vd = RW'(dst);
    do begin
      @(posedge clk); #1;
      start = 1'b0;
      mask_bits = ~m;  // R6: changes after start must not matter
      lat++;
    end while (!done && lat < n + 50);
    check(tag, "R4 latency", VLEN'(lat), VLEN'(exp_lat));
    check(tag, "R2 busy with done", VLEN'(busy), VLEN'(1));
    check(tag, "R8 dirty_set", VLEN'(dirty_set), VLEN'(!bad && n != 0));
    check(tag, "R8 vstart_clr", VLEN'(vstart_clr), VLEN'(!bad));
    check(tag, "R12 illegal", VLEN'(illegal), VLEN'(bad));
    @(posedge clk); #1;
    check(tag, "R2 idle after done", VLEN'({busy, done}), VLEN'(0));
    check(tag, "R7 destination", rf[dst], exp_vd);
  endtask

  task automatic t_reset;
    check("R1", "outputs in reset",
          VLEN'({busy, done, illegal, dirty_set, vstart_clr, rf_wr_en}), VLEN'(0));
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "outputs after reset",
          VLEN'({busy, done, illegal, dirty_set, vstart_clr, rf_wr_en}), VLEN'(0));
  endtask

  task automatic t_ops;
    for (int o = 0; o < 8; o++) begin
      run_case("R5 sew32", o, 2, 0, 0, 0, '0, 10, 1, 4, 9);
      run_case("R5 sew64", o, 3, 0, 0, 0, '0, 5, 2, 12, 10);
      run_case("R5 sew8", o, 0, 0, 0, 0, '0, 23, 3, 16, 11);
    end
  endtask

  task automatic t_groups;
    run_case("R3 R4 one reg", 0, 0, 0, 0, 0, '0, 16, 1, 2, 3);
    run_case("R4 full group", 4, 0, 0, 0, 0, '0, 128, 5, 16, 6);
    run_case("R4 sew16 span", 3, 1, 0, 0, 0, '0, 37, 7, 8, 30);
  endtask

  task automatic t_mask;
    run_case("R6 pattern", 0, 1, 0, 0, 1, {8{16'hA5C3}}, 30, 1, 8, 3);
    run_case("R6 min pattern", 2, 0, 0, 0, 1, {4{32'h0F0F_3CC3}}, 100, 2, 16, 4);
    run_case("R6 none active", 6, 2, 0, 0, 1, '0, 12, 5, 4, 9);
  endtask

  task automatic t_widen;
    run_case("R10 R11 sext8", 2, 0, 1, 1, 0, '0, 40, 1, 16, 3);
    run_case("R10 R11 zext8", 7, 0, 1, 0, 0, '0, 40, 1, 16, 4);
    run_case("R11 sext32 masked", 0, 2, 1, 1, 1, {16{8'h6D}}, 12, 2, 8, 5);
    run_case("R11 zext16", 0, 1, 1, 0, 0, '0, 24, 6, 12, 7);
  endtask

  task automatic t_empty_and_refused;
    run_case("R9 zero length", 0, 1, 0, 0, 0, '0, 0, 1, 2, 3);
    run_case("R9 zero widen", 0, 0, 1, 1, 0, '0, 0, 1, 2, 4);
    run_case("R12 widen 64", 0, 3, 1, 1, 0, '0, 9, 1, 2, 5);
  endtask

  task automatic t_busy_ignore;
    logic [VLEN-1:0] other = rf[20];
    int extra = 0;
    fork
      run_case("R2 first", 0, 0, 0, 0, 0, '0, 20, 1, 8, 19);
      begin
        repeat (6) @(negedge clk);
        start = 1'b1; vd = RW'(20); vl = VLW'(3); sew = 2'd3; widen = 1'b0;
        @(negedge clk);
        start = 1'b0;
      end
    join
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1;
      if (done || busy) extra++;
    end
    check("R2", "no second command", VLEN'(extra), VLEN'(0));
    check("R2", "ignored vd untouched", rf[20], other);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fill_regs(11);
    t_reset;
    t_groups;
    t_ops;
    fill_regs(200);
    t_mask;
    t_widen;
    t_empty_and_refused;
    t_busy_ignore;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule